// File: doc/BRIEF.md
# LAPS Receive Frame Decoder

This block sits on the receive side of a WAN link that carries Ethernet MAC frames in LAPS framing. Its input is a stream of octets that are already aligned to bytes. It finds the 0x7E flags, removes byte transparency and deletes rate-adaptation fill. It checks the four header octets against the values programmed on its configuration pins and checks a 32-bit frame check sequence. It then emits the MAC frame payload as a byte stream, followed by one status beat that gives the outcome.

Both data edges are valid/ready. A beat transfers on any cycle where valid and ready are both high. The decoder produces at most one output beat for each input byte it accepts, so it needs only one output register. It therefore accepts input (`in_ready` high) whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no input is taken. The configuration pins are plain levels and are sampled as each header octet arrives.

Top module: `laps_rx_decoder`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat offered while `out_ready` is low stays unchanged (data, start, end, code) until it is taken. No byte is lost or duplicated under back-pressure.
- R2: After reset the decoder discards every byte until it receives the first 0x7E. Unframed bytes before that flag produce no output.
- R3: Inside a frame, 0x7D followed by a byte x decodes to x XOR 0x20, so 7D 5E gives 7E and 7D 5D gives 7D. The pair 7D DD is deleted and yields no byte.
- R4: The pair 7D 7E inside a frame aborts it. The decoder emits an end beat with code 3, then discards bytes until the next 0x7E, which opens a new frame.
- R5: A 0x7E that follows another flag with no decoded byte in between is fill and produces no beat.
- R6: Decoded bytes 0 to 3 are the header (address, control, SAPI high, SAPI low). The last 4 decoded bytes are the FCS. Neither the header nor the FCS is output. Each payload byte is output once, in order, with `out_sof` set on the first. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, complemented, least significant byte first). A frame is good when the register over all decoded bytes leaves 0xDEBB20E3. The closing flag then yields an end beat with code 0.
- R7: If any header byte differs from `cfg_addr`, `cfg_ctrl`, `cfg_sapi[15:8]` or `cfg_sapi[7:0]` respectively, the end code is 1.
- R8: A frame with a correct header and a bad FCS gets end code 2.
- R9: A frame with more than MAX_LEN decoded bytes (header and FCS included) gets end code 4. A frame of exactly MAX_LEN bytes is not oversize.
- R10: A frame with 1 to 7 decoded bytes gets end code 5. When several faults apply, the code precedence is runt, then oversize, then header, then FCS.
- R11: An end beat has `out_eof`=1, `out_sof`=0 and `out_data`=0. A payload beat has `out_eof`=0 and `out_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_data | input | 8 | Received line byte |
| cfg_addr | input | 8 | Expected address octet |
| cfg_ctrl | input | 8 | Expected control octet |
| cfg_sapi | input | 16 | Expected SAPI, high byte sent first |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 8 | Payload byte (0 on end beats) |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | End beat carrying the verdict |
| out_code | output | 3 | 0 good, 1 header, 2 FCS, 3 abort, 4 oversize, 5 runt |

## Verification
Every result is registered once. A payload byte appears on the cycle after the decoded byte that lies four positions later is accepted. An end beat appears on the cycle after the closing flag, or after the abort pair's 7E, is accepted. The bench drives inputs and samples handshakes on the falling edge, between the edge that accepts a byte and the edge that presents its result. It collects every transferred beat in order and compares only after each frame has been followed by eight idle cycles, which is enough for the single pending beat to drain even under a two-in-three ready pattern.

// File: rtl/laps_rx_pkg.sv
package laps_rx_pkg;
  typedef enum logic [2:0] {
    RC_GOOD  = 3'd0,
    RC_HDR   = 3'd1,
    RC_FCS   = 3'd2,
    RC_ABORT = 3'd3,
    RC_LONG  = 3'd4,
    RC_RUNT  = 3'd5
  } rc_e;

  localparam logic [7:0]  FLAG_OCT    = 8'h7E;
  localparam logic [7:0]  ESC_OCT     = 8'h7D;
  localparam logic [7:0]  FILL_OCT    = 8'hDD;
  localparam logic [7:0]  ESC_MASK    = 8'h20;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam int          HDR_LEN     = 4;
  localparam int          FCS_LEN     = 4;
endpackage

// File: rtl/laps_rx_unescape.sv
module laps_rx_unescape
  import laps_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] in_byte,
  output logic       d_valid,
  output logic [7:0] d_byte,
  output logic       close,
  output logic       abrt
);
  logic hunt, esc;

  always_comb begin
    d_valid = 1'b0;
    d_byte  = in_byte;
    close   = 1'b0;
    abrt    = 1'b0;
    if (fire && !hunt) begin
      if (esc) begin
        if (in_byte == FLAG_OCT) abrt = 1'b1;
        else if (in_byte != FILL_OCT) begin
          d_valid = 1'b1;
          d_byte  = in_byte ^ ESC_MASK;
        end
      end else if (in_byte == FLAG_OCT) begin
        close = 1'b1;
      end else if (in_byte != ESC_OCT) begin
        d_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunt <= 1'b1;
      esc  <= 1'b0;
    end else if (fire) begin
      if (hunt) begin
        if (in_byte == FLAG_OCT) hunt <= 1'b0;
        esc <= 1'b0;
      end else if (esc) begin
        esc <= 1'b0;
        if (in_byte == FLAG_OCT) hunt <= 1'b1;
      end else begin
        esc <= (in_byte == ESC_OCT);
      end
    end
  end

  // R3: a line byte yields at most one decode event
  a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_valid, close, abrt}));

  // R4: the byte after an abort never decodes or closes a frame
  a_r4_abort_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    abrt |=> !d_valid && !close);
endmodule

// File: rtl/laps_rx_crc32.sv
module laps_rx_crc32
  import laps_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        clr,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ CRC_POLY_R) : (x >> 1);
    return x;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= 32'hFFFF_FFFF;
    else if (en)       crc <= crc_step(crc, data);
  end

  // R6: every frame boundary restarts the check register at its preset
  a_r6_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == 32'hFFFF_FFFF);
endmodule

// File: rtl/laps_rx_decoder.sv
module laps_rx_decoder
  import laps_rx_pkg::*;
#(
  parameter int MAX_LEN = 2016
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_ctrl,
  input  logic [15:0] cfg_sapi,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic [2:0]  out_code
);
  localparam int LW = $clog2(MAX_LEN + 2);
  localparam int HW = $clog2(HDR_LEN);
  localparam logic [LW-1:0] LEN_SAT = {LW{1'b1}};
  localparam logic [LW-1:0] HDR_L   = LW'(HDR_LEN);
  localparam logic [LW-1:0] MIN_L   = LW'(HDR_LEN + FCS_LEN);
  localparam logic [LW-1:0] MAX_L   = LW'(MAX_LEN);

  logic        fire, d_valid, close, abrt;
  logic [7:0]  d_byte;
  logic [31:0] crc;
  logic [LW-1:0] len;
  logic        hdr_bad;
  logic [7:0]  dly [FCS_LEN];
  logic [7:0]  hdr_ref [HDR_LEN];
  rc_e         verdict;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  assign hdr_ref[0] = cfg_addr;
  assign hdr_ref[1] = cfg_ctrl;
  assign hdr_ref[2] = cfg_sapi[15:8];
  assign hdr_ref[3] = cfg_sapi[7:0];

  laps_rx_unescape u_unesc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .in_byte(in_data),
    .d_valid(d_valid), .d_byte(d_byte), .close(close), .abrt(abrt)
  );

  laps_rx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .en(d_valid), .clr(close || abrt),
    .data(d_byte), .crc(crc)
  );

  // FCS hold-back line: the last FCS_LEN decoded bytes never leave
  for (genvar g = 0; g < FCS_LEN; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) dly[g] <= 8'h00;
      else if (d_valid) dly[g] <= (g == 0) ? d_byte : dly[(g == 0) ? 0 : g - 1];
    end
  end

  always_comb begin
    if (len < MIN_L)              verdict = RC_RUNT;
    else if (len > MAX_L)         verdict = RC_LONG;
    else if (hdr_bad)             verdict = RC_HDR;
    else if (crc != CRC_RESIDUE)  verdict = RC_FCS;
    else                          verdict = RC_GOOD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len       <= '0;
      hdr_bad   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_code  <= RC_GOOD;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (d_valid) begin
        if (len != LEN_SAT) len <= len + 1'b1;
        if (len < HDR_L && d_byte != hdr_ref[len[HW-1:0]]) hdr_bad <= 1'b1;
        if (len >= MIN_L) begin
          out_valid <= 1'b1;
          out_data  <= dly[FCS_LEN-1];
          out_sof   <= (len == MIN_L);
          out_eof   <= 1'b0;
          out_code  <= RC_GOOD;
        end
      end
      if (abrt || (close && len != '0)) begin
        out_valid <= 1'b1;
        out_data  <= 8'h00;
        out_sof   <= 1'b0;
        out_eof   <= 1'b1;
        out_code  <= abrt ? RC_ABORT : verdict;
        len       <= '0;
        hdr_bad   <= 1'b0;
      end
    end
  end

  // R1: a stalled beat is held unchanged
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_code));

  // R11: a frame-start beat is a payload beat with a neutral code
  a_r11_sof_not_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !out_eof && out_code == RC_GOOD);
endmodule

// File: tb/laps_rx_decoder_test.sv
module laps_rx_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [7:0]  cfg_addr = 8'h04;
  logic [7:0]  cfg_ctrl = 8'h03;
  logic [15:0] cfg_sapi = 16'hFE01;
  logic        out_valid, out_sof, out_eof;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [2:0]  out_code;

  int checks = 0, fails = 0, cyc = 0;
  bit bp = 1'b0;
  byte unsigned tx_body[$], exp_pay[$], got_d[$];
  bit got_sof[$], got_eof[$];
  logic [2:0] got_c[$];

  always #10 clk = ~clk;

  laps_rx_decoder #(.MAX_LEN(40)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl), .cfg_sapi(cfg_sapi),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_code(out_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got_d.push_back(out_data); got_sof.push_back(out_sof);
      got_eof.push_back(out_eof); got_c.push_back(out_code);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_q();
    got_d.delete(); got_sof.delete(); got_eof.delete(); got_c.delete();
  endtask

  function automatic logic [31:0] fcs_of();
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (tx_body[i]) begin
      c = c ^ {24'h0, tx_body[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int n, input int seed, input logic [7:0] a, input logic [7:0] c, input logic [15:0] s);
    logic [31:0] f;
    exp_pay.delete(); tx_body.delete();
    tx_body.push_back(a); tx_body.push_back(c); tx_body.push_back(s[15:8]); tx_body.push_back(s[7:0]);
    for (int i = 0; i < n; i++) begin
      exp_pay.push_back(8'(seed + i * 13)); tx_body.push_back(8'(seed + i * 13));
    end
    f = fcs_of();
    for (int i = 0; i < 4; i++) tx_body.push_back(f[8*i +: 8]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    forever begin
      if (in_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_body(input int fill_pos);
    send_byte(8'h7E);
    foreach (tx_body[i]) begin
      if (i == fill_pos) begin send_byte(8'h7D); send_byte(8'hDD); end
      if (tx_body[i] == 8'h7E || tx_body[i] == 8'h7D) begin
        send_byte(8'h7D); send_byte(tx_body[i] ^ 8'h20);
      end else send_byte(tx_body[i]);
    end
    send_byte(8'h7E);
    idle();
  endtask

  task automatic expect_frame(input string req, input logic [2:0] code);
    int bad = 0;
    int last;
    chk(got_d.size() == exp_pay.size() + 1, req, "beat count", got_d.size(), exp_pay.size() + 1);
    if (got_d.size() == exp_pay.size() + 1) begin
      foreach (exp_pay[i])
        if (got_d[i] != exp_pay[i] || got_eof[i] || got_sof[i] != (i == 0) || got_c[i] != 3'd0) bad++;
      chk(bad == 0, req, "payload mismatches", bad, 0);
      last = got_d.size() - 1;
      chk(got_eof[last] && !got_sof[last] && got_d[last] == 8'h00 && got_c[last] == code,
          req, "end beat code", got_c[last], code);
    end
    clr_q();
  endtask

  task automatic t_reset();
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_hunt();
    send_byte(8'h04); send_byte(8'h03); send_byte(8'h7D); send_byte(8'h5E);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
    idle();
    chk(got_d.size() == 0, "R2", "beats before first flag", got_d.size(), 0);
    clr_q();
  endtask

  task automatic t_good();
    build(6, 8'h31, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R6 R11 good frame", 3'd0);
  endtask

  task automatic t_escape();
    logic [31:0] f;
    exp_pay = '{8'h7E, 8'h7D, 8'hDD, 8'h5E, 8'h20, 8'h00, 8'h7D, 8'h7E};
    tx_body = '{cfg_addr, cfg_ctrl, cfg_sapi[15:8], cfg_sapi[7:0]};
    foreach (exp_pay[i]) tx_body.push_back(exp_pay[i]);
    f = fcs_of();
    for (int i = 0; i < 4; i++) tx_body.push_back(f[8*i +: 8]);
    send_body(6);
    expect_frame("R3 escapes and fill pair", 3'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 5; i++) send_byte(8'h7E);
    idle();
    chk(got_d.size() == 0, "R5", "beats from flag fill", got_d.size(), 0);
    clr_q();
  endtask

  task automatic t_hdr();
    build(5, 8'h50, cfg_addr, 8'h13, cfg_sapi);
    send_body(-1);
    expect_frame("R7 control mismatch", 3'd1);
    build(5, 8'h51, cfg_addr, cfg_ctrl, 16'hFE02);
    send_body(-1);
    expect_frame("R7 SAPI mismatch", 3'd1);
  endtask

  task automatic t_fcs();
    build(7, 8'h60, cfg_addr, cfg_ctrl, cfg_sapi);
    tx_body[5] = tx_body[5] ^ 8'h01;
    exp_pay[1] = exp_pay[1] ^ 8'h01;
    send_body(-1);
    expect_frame("R8 FCS error", 3'd2);
  endtask

  task automatic t_abort();
    send_byte(8'h7E);
    send_byte(cfg_addr); send_byte(cfg_ctrl); send_byte(cfg_sapi[15:8]); send_byte(cfg_sapi[7:0]);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h7D); send_byte(8'h7E);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    idle();
    chk(got_d.size() == 1 && got_eof[0] && got_c[0] == 3'd3, "R4", "abort end beat code",
        got_d.size() == 1 ? int'(got_c[0]) : -1, 3);
    clr_q();
    build(4, 8'h70, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R4 recovery after abort", 3'd0);
  endtask

  task automatic t_runt();
    send_byte(8'h7E);
    send_byte(cfg_addr); send_byte(cfg_ctrl); send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
    send_byte(8'h7E);
    idle();
    chk(got_d.size() == 1 && got_eof[0] && got_c[0] == 3'd5, "R10", "runt code with bad header",
        got_d.size() == 1 ? int'(got_c[0]) : -1, 5);
    clr_q();
    build(0, 0, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R10 eight-byte frame is not runt", 3'd0);
  endtask

  task automatic t_long();
    build(32, 8'h05, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R9 exactly MAX_LEN", 3'd0);
    build(33, 8'h06, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R9 one over MAX_LEN", 3'd4);
    build(40, 8'h07, 8'h99, cfg_ctrl, cfg_sapi);
    send_body(-1);
    expect_frame("R10 oversize outranks header", 3'd4);
  endtask

  task automatic t_backpressure();
    bp = 1'b1;
    build(20, 8'h21, cfg_addr, cfg_ctrl, cfg_sapi);
    send_body(3);
    expect_frame("R1 back-pressure", 3'd0);
    bp = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hunt();
    t_good();
    t_escape();
    t_fill();
    t_hdr();
    t_fcs();
    t_abort();
    t_runt();
    t_long();
    t_backpressure();
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
  end
endmodule